// File: doc/BRIEF.md
# Configurable Multi-Source Interrupt Combiner

This block gathers a bank of asynchronous interrupt request lines into a single registered interrupt output for an upstream interrupt controller. Every line passes through a two-flop synchronizer. A per-source pair of configuration bits selects how the line is detected: high level, low level, rising edge or falling edge. Each detected event latches a status bit. A status bit drives the combined output only when its enable bit is set.

Software reaches the block over a simple 32-bit memory-mapped bus with single-cycle write and read strobes and byte addresses. The bus gives access to the status word, the enable mask, a write-one-to-set word for software interrupts, a write-one-to-clear word for acknowledgement, and the polarity and edge-select words. A registered index of the lowest-numbered pending source, with a valid flag, lets a handler scan from bit 0 upward without reading the status word.

Top module: `irq_combiner`

## Requirements
- R1: After reset, the enable, polarity and edge-select words read 0, and `irq_o` and `low_vld_o` are 0.
- R2: The byte offsets are: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, edge-select 0x14. Enable, polarity and edge-select read back the value last written. Set and clear read as 0.
- R3: When a source's edge-select bit is 0, the source is level triggered, active high if its polarity bit is 1 and active low if it is 0. Its status bit is set on every cycle the synchronized line is at the active level, so a clear has no effect while the line stays active. The bit stays set after the line goes inactive until it is cleared.
- R4: When a source's edge-select bit is 1, the source latches its status bit on a rising edge if its polarity bit is 1, or on a falling edge if it is 0. The opposite transition has no effect, and the bit holds until it is cleared.
- R5: Writing 1 to a bit of the clear word clears that status bit. Bits written as 0 leave their status unchanged.
- R6: Writing 1 to a bit of the set word forces that status bit to 1. A set or a detected event in the same cycle as a clear takes priority, and the bit stays 1.
- R7: `irq_o` is 1 exactly when some status bit and its enable bit are both 1, one cycle after that condition holds. A masked source still latches status.
- R8: A change on a request line reaches its status bit on the third rising clock edge after it is sampled, through two synchronizer stages and one detection stage.
- R9: `low_idx_o` gives the lowest-numbered source whose status and enable bits are both 1, and `low_vld_o` shows that such a source exists. Both are registered with the same timing as `irq_o`.
- R10: Writes to the status offset and to misaligned or unmapped addresses are ignored. `rdata_o` carries the addressed word one cycle after `rd_en_i`, and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Asynchronous interrupt request lines |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt output |
| low_idx_o | output | 5 | Lowest pending source number |
| low_vld_o | output | 1 | Lowest pending index is valid |

## Verification
The assertions assume that the bus never raises a write and a read strobe in the same cycle. They also assume that request lines may change at any time relative to the clock, but are held stable long enough to pass both synchronizer stages. The stimulus drives every bus access and every request change on the falling clock edge. It holds each request level for several cycles before any check, and it lets all lines settle before it clears the status left over from reconfiguring the trigger mode. The sweep covers all four trigger modes and a range of source positions, including both end bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Word index of each register (byte address bits [4:2]).
  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_ENABLE = 3'd1,
    RG_SETSW  = 3'd2,
    RG_ACK    = 3'd3,
    RG_POL    = 3'd4,
    RG_EDGE   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic prev_i,
  input  logic edge_sel_i,
  input  logic pol_i,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o
);
  logic active;
  logic transition;
  logic hit;
  logic status_q;

  always_comb begin
    active     = pol_i ? lvl_i : ~lvl_i;
    transition = pol_i ? (lvl_i & ~prev_i) : (~lvl_i & prev_i);
    hit        = edge_sel_i ? transition : active;
  end

  always_ff @(posedge clk) begin
    if (rst)                status_q <= 1'b0;
    else if (hit || set_i)  status_q <= 1'b1;
    else if (clr_i)         status_q <= 1'b0;
  end

  assign status_o = status_q;

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
    (!edge_sel_i && active) |=> status_q); // R3
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr_i) |=> status_q); // R4
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (rst)
    set_i |=> status_q); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !hit) |=> !status_q); // R5
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  logic [IDX_W-1:0] idx_d;
  logic             vld_d;

  always_comb begin
    idx_d = '0;
    vld_d = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_d = IDX_W'(i);
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
      vld_o <= 1'b0;
    end else begin
      idx_o <= idx_d;
      vld_o <= vld_d;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vld_o == $past(|vec_i)); // R9
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  low_idx_o,
  output logic              low_vld_o
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] sync_lvl, sync_prev;
  logic [NUM_SRC-1:0] en_q, pol_q, edge_q;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] set_stb, clr_stb;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] wr_bits;
  logic               aligned;
  logic [2:0]         word_sel;
  logic               irq_q;

  assign aligned  = (addr_i[1:0] == 2'b00) && (addr_i >> 5 == '0);
  assign word_sel = addr_i[4:2];
  assign wr_bits  = wdata_i[NUM_SRC-1:0];

  irq_sync_bank #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .async_i(req_i),
    .sync_o(sync_lvl), .prev_o(sync_prev)
  );

  always_comb begin
    set_stb = '0;
    clr_stb = '0;
    if (wr_en_i && aligned && word_sel == RG_SETSW) set_stb = wr_bits;
    if (wr_en_i && aligned && word_sel == RG_ACK)   clr_stb = wr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else if (wr_en_i && aligned) begin
      case (word_sel)
        RG_ENABLE: en_q   <= wr_bits;
        RG_POL:    pol_q  <= wr_bits;
        RG_EDGE:   edge_q <= wr_bits;
        default:   ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst(rst),
      .lvl_i(sync_lvl[g]), .prev_i(sync_prev[g]),
      .edge_sel_i(edge_q[g]), .pol_i(pol_q[g]),
      .set_i(set_stb[g]), .clr_i(clr_stb[g]),
      .status_o(status[g])
    );
  end

  assign pending = status & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending;
  end
  assign irq_o = irq_q;

  irq_lowest_enc #(.WIDTH(NUM_SRC)) u_enc (
    .clk(clk), .rst(rst), .vec_i(pending),
    .idx_o(low_idx_o), .vld_o(low_vld_o)
  );

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (word_sel)
        RG_STATUS: rd_word[NUM_SRC-1:0] = status;
        RG_ENABLE: rd_word[NUM_SRC-1:0] = en_q;
        RG_POL:    rd_word[NUM_SRC-1:0] = pol_q;
        RG_EDGE:   rd_word[NUM_SRC-1:0] = edge_q;
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_word;
    else              rdata_o <= '0;
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(status & en_q))); // R7
  AST_VLD_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    low_vld_o == irq_o); // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> rdata_o == '0); // R10
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && rd_en_i)); // R10
endmodule

// File: tb/irq_combiner_bench.sv
`timescale 1ns/1ps
module irq_combiner_bench;
  localparam int N = 32;
  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] req = '0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [4:0] low_idx;
  logic low_vld;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_combiner u_irq_combiner (
    .clk(clk), .rst(rst), .req_i(req), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .low_idx_o(low_idx), .low_vld_o(low_vld)
  );

  localparam logic [4:0] A_ST = 5'h00, A_EN = 5'h04, A_SET = 5'h08,
                         A_CLR = 5'h0C, A_POL = 5'h10, A_EDG = 5'h14;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    int bits[6] = '{0, 1, 7, 15, 30, 31};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 vld", {31'd0, low_vld}, 0);
    rd(A_EN, v);  chk("R1 enable", v, 0);
    rd(A_POL, v); chk("R1 pol", v, 0);
    rd(A_EDG, v); chk("R1 edge", v, 0);
    // R8 latency: reset mode is active-low level, inputs low -> status set,
    // but masked, so irq stays low (R7)
    settle();
    chk("R7 masked irq", {31'd0, irq}, 0);
    rd(A_ST, v); chk("R7 masked latch", v, 32'hFFFF_FFFF);

    // R2 readback
    wr(A_EN, 32'hA5A5_0F0F); rd(A_EN, v); chk("R2 en rb", v, 32'hA5A5_0F0F);
    wr(A_POL, 32'h1234_5678); rd(A_POL, v); chk("R2 pol rb", v, 32'h1234_5678);
    wr(A_EDG, 32'h8765_4321); rd(A_EDG, v); chk("R2 edge rb", v, 32'h8765_4321);
    rd(A_SET, v); chk("R2 set reads 0", v, 0);
    rd(A_CLR, v); chk("R2 clr reads 0", v, 0);

    wr(A_EN, 32'hFFFF_FFFF);
    // Sweep all four modes: m[1]=edge, m[0]=polarity
    for (int m = 0; m < 4; m++) begin
      logic [31:0] idle;
      bit is_edge, pol;
      is_edge = m[1]; pol = m[0];
      idle = pol ? 32'h0 : 32'hFFFF_FFFF;
      wr(A_POL, pol ? 32'hFFFF_FFFF : 0);
      wr(A_EDG, is_edge ? 32'hFFFF_FFFF : 0);
      @(negedge clk); req = idle;
      settle();
      wr(A_CLR, 32'hFFFF_FFFF);
      settle();
      rd(A_ST, v); chk(is_edge ? "R4 idle" : "R3 idle", v, 0);
      chk("R7 idle irq", {31'd0, irq}, 0);
      for (int k = 0; k < 6; k++) begin
        int b;
        logic [31:0] one;
        b = bits[k];
        one = 32'h1 << b;
        @(negedge clk); req = idle ^ one;
        // R8: status updates on third rising edge
        @(negedge clk); @(negedge clk);
        rd(A_ST, v); // read samples after third edge
        chk("R8 latency", v, one);
        @(negedge clk);
        chk("R7 irq", {31'd0, irq}, 1);
        chk("R9 idx", {27'd0, low_idx}, b);
        chk("R9 vld", {31'd0, low_vld}, 1);
        if (!is_edge) begin
          wr(A_CLR, one); settle();
          rd(A_ST, v); chk("R3 clear while active", v, one);
        end
        @(negedge clk); req = idle;
        settle();
        rd(A_ST, v); chk(is_edge ? "R4 hold" : "R3 hold", v, one);
        wr(A_CLR, one); settle();
        rd(A_ST, v); chk("R5 cleared", v, 0);
        chk("R7 irq low", {31'd0, irq}, 0);
      end
    end

    // Now active-high level, inputs idle low
    wr(A_POL, 32'hFFFF_FFFF); wr(A_EDG, 0);
    @(negedge clk); req = '0; settle();
    wr(A_CLR, 32'hFFFF_FFFF); settle();
    // R6 software set, R5 zeros ignored
    wr(A_SET, 32'h8000_0001); rd(A_ST, v); chk("R6 set", v, 32'h8000_0001);
    wr(A_CLR, 32'h0000_0001); rd(A_ST, v); chk("R5 partial", v, 32'h8000_0000);
    @(negedge clk);
    chk("R9 idx top", {27'd0, low_idx}, 31);
    // R10 writes to status ignored
    wr(A_ST, 32'h0000_FFFF); rd(A_ST, v); chk("R10 status wr", v, 32'h8000_0000);
    wr(5'h06, 32'hFFFF_FFFF); rd(A_EN, v); chk("R10 misaligned", v, 32'hFFFF_FFFF);
    // R9 lowest index sweep with masking
    for (int i = 0; i < 31; i++) begin
      wr(A_SET, 32'h1 << i);
      @(negedge clk);
      chk("R9 sweep", {27'd0, low_idx}, i);
      wr(A_CLR, 32'h1 << i);
    end
    wr(A_EN, 32'h7FFF_FFFF); @(negedge clk); @(negedge clk);
    chk("R7 masked off", {31'd0, irq}, 0);
    chk("R9 masked vld", {31'd0, low_vld}, 0);
    rd(A_ST, v); chk("R7 status kept", v, 32'h8000_0000);
    @(negedge clk);
    chk("R10 rdata idle", rdata, 0);
    done = 1;
    report();
  end
endmodule